// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block keeps the reservations that make a load-linked / store-conditional pair act as one atomic read-modify-write for several harts that share memory. Every hart presents at most one memory request per cycle. The request is a plain load, a load-linked, a plain store or a store-conditional. A load-linked places the addressed cache line in one of the hart's reservation slots. A later store-conditional from that hart commits its write only if a slot still holds that line. If it does not, the monitor reports failure and suppresses the write.

Reservations are compared at cache-line granularity. A reservation is dropped when any of these happen to its line:

- a committed write by any hart,
- a write by an agent outside the hart group,
- an eviction of the line,
- a context switch on the owning hart.

The data array itself is out of scope. The monitor drives one registered write port per hart, and memory applies that write. Load data is returned by the memory path, so the monitor does not carry it.

Every request gets a registered response one cycle later. The response is a valid flag and, for a store-conditional, a success flag. The write port fires in the same cycle as that response.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked from hart h reserves the line `addr >> log2(LINE_BYTES)`. A following store-conditional from h to any byte of that line succeeds. Success means `rsp_sc_ok[h]=1` and `mem_we[h]=1`, with the request's address and data on the write port, one cycle after the request.
- R2: A store-conditional whose line is not held in a valid slot of its hart fails. Failure means `rsp_sc_ok=0` and `mem_we=0`.
- R3: Every store-conditional clears the issuing hart's slot for that line, whether it succeeds or fails. A second store-conditional to that line without a new load-linked fails.
- R4: A committed write (plain store or successful store-conditional) by another hart to a reserved line clears that reservation. A write to a different line leaves it intact.
- R5: An outside-agent write (`ext_wr_valid`, `ext_wr_addr`) clears every reservation of any hart on that line.
- R6: An eviction (`evict_valid`, `evict_addr`) clears every reservation of any hart on that line.
- R7: `ctx_switch[h]` clears all reservations of hart h and of no other hart.
- R8: A plain store from hart h to a line that h has reserved clears h's own reservation.
- R9: Each hart has SLOTS slots, so that many lines can be reserved at once. A load-linked takes, in this order of preference:
  - a slot already holding the line,
  - else the lowest free slot,
  - else the slot named by a per-hart victim pointer. The pointer starts at slot 0 and advances by one (wrapping) after each replacement.
- R10: When store-conditionals from several harts to one line all hold reservations in the same cycle, only the lowest-numbered hart succeeds. The others fail and write nothing, and their slots for the line are cleared.
- R11: A store-conditional fails if, in its own cycle, any of these occurs:
  - an outside write or an eviction to its line,
  - a context switch of its hart,
  - a plain store by another hart to its line.
- R12: A load-linked leaves no reservation if, in its own cycle, there is a clearing event for its line or a context switch of its hart.
- R13: Every request gives `rsp_valid[h]=1` one cycle later. Plain loads change no reservation and never write. Plain stores always write. Op encoding: 00 load, 01 load-linked, 10 store, 11 store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | HARTS | Request present, one bit per hart |
| req_op | input | 2*HARTS | Request opcode per hart (00 ld, 01 ll, 10 st, 11 sc) |
| req_addr | input | AW*HARTS | Byte address per hart |
| req_wdata | input | DW*HARTS | Store data per hart |
| ext_wr_valid | input | 1 | Write by an agent outside the hart group |
| ext_wr_addr | input | AW | Address of that outside write |
| evict_valid | input | 1 | A cache line is evicted |
| evict_addr | input | AW | Address of the evicted line |
| ctx_switch | input | HARTS | Context switch per hart |
| rsp_valid | output | HARTS | Response for last cycle's request |
| rsp_sc_ok | output | HARTS | Store-conditional succeeded |
| mem_we | output | HARTS | Write enable of the per-hart write port |
| mem_addr | output | AW*HARTS | Write address per hart |
| mem_wdata | output | DW*HARTS | Write data per hart |

## Verification
The hard case is a store-conditional that meets a clearing event for its own line in the same cycle. The clearing event is a competing store-conditional, a plain store by another hart, an outside write, an eviction or a context switch. The bench arranges each of these three ways: in the cycle between the load-linked and the store-conditional, in the store-conditional's own cycle, and in the load-linked's cycle. It then judges the success flag and the write enable against the outcome computed from R11, R12 and R10. For two- and three-way contests, the expected winner is the lowest index among harts holding the line. The losers are probed afterwards to confirm their slots were cleared.

// File: rtl/llsc_pkg.sv
// Shared definitions for the reservation monitor.
// Assumes a two-bit opcode per hart request.
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_LL    = 2'b01,
        OP_STORE = 2'b10,
        OP_SC    = 2'b11
    } llsc_op_e;
endpackage

// File: rtl/llsc_slot_bank.sv
// Reservation slots of one hart.
// Reports whether the queried line is held, applies clears and allocates on load-linked.
// Assumes at most one of set_en / own_clr_en is high per cycle (one op per hart).
module llsc_slot_bank #(
    parameter int SLOTS = 2,
    parameter int TW    = 12,
    parameter int KILLS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TW-1:0]       query_tag,
    output logic                hit,
    input  logic                set_en,
    input  logic [TW-1:0]       set_tag,
    input  logic                own_clr_en,
    input  logic                ctx_clr,
    input  logic [KILLS-1:0]    kill_valid,
    input  logic [KILLS*TW-1:0] kill_tag
);
    localparam int VPW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOTS-1:0] vld_q, vld_nx, slot_hit, killed, keep;
    logic [TW-1:0]    tag_q [SLOTS];
    logic [VPW-1:0]   victim_q, alloc_idx;
    logic             set_blocked, do_set, replace;

    // Which slots hold the queried line
    always_comb begin
        for (int s = 0; s < SLOTS; s++)
            slot_hit[s] = vld_q[s] && (tag_q[s] == query_tag);
        hit = |slot_hit;
    end

    // Clearing events against held lines and against the line being linked
    always_comb begin
        set_blocked = ctx_clr;
        for (int s = 0; s < SLOTS; s++) begin
            killed[s] = 1'b0;
            for (int k = 0; k < KILLS; k++)
                if (kill_valid[k] && kill_tag[k*TW +: TW] == tag_q[s])
                    killed[s] = 1'b1;
            keep[s] = vld_q[s] && !killed[s] && !ctx_clr && !(own_clr_en && slot_hit[s]);
        end
        for (int k = 0; k < KILLS; k++)
            if (kill_valid[k] && kill_tag[k*TW +: TW] == set_tag)
                set_blocked = 1'b1;
    end

    // Slot choice: same line, else lowest free, else victim pointer
    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_idx = victim_q;
        replace   = 1'b1;
        for (int s = 0; s < SLOTS; s++)
            if (!found && keep[s] && tag_q[s] == set_tag) begin
                found = 1'b1; alloc_idx = VPW'(s); replace = 1'b0;
            end
        for (int s = 0; s < SLOTS; s++)
            if (!found && !keep[s]) begin
                found = 1'b1; alloc_idx = VPW'(s); replace = 1'b0;
            end
        do_set = set_en && !set_blocked;
        vld_nx = keep;
        if (do_set)
            vld_nx[alloc_idx] = 1'b1;
    end

    // Valid bits and victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            victim_q <= '0;
        end else begin
            vld_q <= vld_nx;
            if (do_set && replace)
                victim_q <= (victim_q == VPW'(SLOTS-1)) ? '0 : victim_q + 1'b1;
        end
    end

    // Line tag capture on allocation
    always_ff @(posedge clk) begin
        if (do_set)
            tag_q[alloc_idx] <= set_tag;
    end
endmodule

// File: rtl/llsc_sc_resolve.sv
// Decides which store-conditionals commit this cycle and which writes reach memory.
// Assumes hit[] reflects reservation state at the start of the cycle.
module llsc_sc_resolve #(
    parameter int HARTS = 4,
    parameter int TW    = 12
) (
    input  logic [HARTS-1:0]    is_sc,
    input  logic [HARTS-1:0]    is_st,
    input  logic [HARTS-1:0]    hit,
    input  logic [HARTS*TW-1:0] tag,
    input  logic [HARTS-1:0]    ctx,
    input  logic                ext_valid,
    input  logic [TW-1:0]       ext_tag,
    input  logic                evc_valid,
    input  logic [TW-1:0]       evc_tag,
    output logic [HARTS-1:0]    sc_ok,
    output logic [HARTS-1:0]    commit
);
    logic [HARTS-1:0] blocked, cand;

    // Same-cycle events that void a store-conditional
    always_comb begin
        for (int h = 0; h < HARTS; h++) begin
            blocked[h] = ctx[h]
                       || (ext_valid && ext_tag == tag[h*TW +: TW])
                       || (evc_valid && evc_tag == tag[h*TW +: TW]);
            for (int j = 0; j < HARTS; j++)
                if (j != h && is_st[j] && tag[j*TW +: TW] == tag[h*TW +: TW])
                    blocked[h] = 1'b1;
            cand[h] = is_sc[h] && hit[h] && !blocked[h];
        end
    end

    // Lowest-numbered candidate per line wins
    always_comb begin
        for (int h = 0; h < HARTS; h++) begin
            sc_ok[h] = cand[h];
            for (int j = 0; j < h; j++)
                if (cand[j] && tag[j*TW +: TW] == tag[h*TW +: TW])
                    sc_ok[h] = 1'b0;
            commit[h] = is_st[h] || sc_ok[h];
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
// Top of the reservation monitor.
// Decodes hart requests, holds per-hart slot banks, resolves store-conditionals
// and registers responses and the per-hart write port.
// Assumes one request per hart per cycle and line size a power of two.
module llsc_monitor #(
    parameter int HARTS      = 4,
    parameter int SLOTS      = 2,
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HARTS-1:0]    req_valid,
    input  logic [HARTS*2-1:0]  req_op,
    input  logic [HARTS*AW-1:0] req_addr,
    input  logic [HARTS*DW-1:0] req_wdata,
    input  logic                ext_wr_valid,
    input  logic [AW-1:0]       ext_wr_addr,
    input  logic                evict_valid,
    input  logic [AW-1:0]       evict_addr,
    input  logic [HARTS-1:0]    ctx_switch,
    output logic [HARTS-1:0]    rsp_valid,
    output logic [HARTS-1:0]    rsp_sc_ok,
    output logic [HARTS-1:0]    mem_we,
    output logic [HARTS*AW-1:0] mem_addr,
    output logic [HARTS*DW-1:0] mem_wdata
);
    import llsc_pkg::*;

    localparam int OFF   = $clog2(LINE_BYTES);
    localparam int TW    = AW - OFF;
    localparam int KILLS = HARTS + 2;

    logic [HARTS-1:0]    is_ll, is_sc, is_st, hit, sc_ok, commit;
    logic [HARTS*TW-1:0] tag;
    logic [TW-1:0]       ext_tag, evc_tag;
    logic [KILLS-1:0]    kill_valid;
    logic [KILLS*TW-1:0] kill_tag;

    // Request decode and line extraction
    always_comb begin
        for (int h = 0; h < HARTS; h++) begin
            is_ll[h] = req_valid[h] && llsc_op_e'(req_op[h*2 +: 2]) == OP_LL;
            is_sc[h] = req_valid[h] && llsc_op_e'(req_op[h*2 +: 2]) == OP_SC;
            is_st[h] = req_valid[h] && llsc_op_e'(req_op[h*2 +: 2]) == OP_STORE;
            tag[h*TW +: TW] = req_addr[h*AW+OFF +: TW];
        end
        ext_tag = ext_wr_addr[AW-1:OFF];
        evc_tag = evict_addr[AW-1:OFF];
    end

    // Clearing event list seen by every slot bank
    always_comb begin
        kill_valid[0]        = ext_wr_valid;
        kill_tag[0 +: TW]    = ext_tag;
        kill_valid[1]        = evict_valid;
        kill_tag[TW +: TW]   = evc_tag;
        for (int h = 0; h < HARTS; h++) begin
            kill_valid[2+h]          = commit[h];
            kill_tag[(2+h)*TW +: TW] = tag[h*TW +: TW];
        end
    end

    llsc_sc_resolve #(.HARTS(HARTS), .TW(TW)) resolve_i (
        .is_sc(is_sc), .is_st(is_st), .hit(hit), .tag(tag), .ctx(ctx_switch),
        .ext_valid(ext_wr_valid), .ext_tag(ext_tag),
        .evc_valid(evict_valid), .evc_tag(evc_tag),
        .sc_ok(sc_ok), .commit(commit)
    );

    for (genvar h = 0; h < HARTS; h++) begin : g_bank
        llsc_slot_bank #(.SLOTS(SLOTS), .TW(TW), .KILLS(KILLS)) bank_i (
            .clk(clk), .rst_n(rst_n),
            .query_tag(tag[h*TW +: TW]), .hit(hit[h]),
            .set_en(is_ll[h]), .set_tag(tag[h*TW +: TW]),
            .own_clr_en(is_sc[h]), .ctx_clr(ctx_switch[h]),
            .kill_valid(kill_valid), .kill_tag(kill_tag)
        );
    end

    // Registered responses and write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_sc_ok <= '0;
            mem_we    <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_sc_ok <= sc_ok;
            mem_we    <= commit;
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
// Property checker for the reservation monitor, bound to every instance.
// Assumes the op encoding of llsc_pkg.
module llsc_monitor_chk #(
    parameter int HARTS      = 4,
    parameter int AW         = 16,
    parameter int LINE_BYTES = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [HARTS-1:0]    req_valid,
    input logic [HARTS*2-1:0]  req_op,
    input logic [HARTS*AW-1:0] req_addr,
    input logic                ext_wr_valid,
    input logic [AW-1:0]       ext_wr_addr,
    input logic                evict_valid,
    input logic [AW-1:0]       evict_addr,
    input logic [HARTS-1:0]    ctx_switch,
    input logic [HARTS-1:0]    rsp_valid,
    input logic [HARTS-1:0]    rsp_sc_ok,
    input logic [HARTS-1:0]    mem_we,
    input logic [HARTS*AW-1:0] mem_addr
);
    localparam int OFF = $clog2(LINE_BYTES);

    for (genvar h = 0; h < HARTS; h++) begin : g_h
        // R13: every request answered one cycle later
        p_rsp_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[h] |=> rsp_valid[h]);
        p_no_spurious_rsp_r13: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[h] |=> !rsp_valid[h] && !mem_we[h]);
        p_store_writes_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[h] && req_op[h*2 +: 2] == 2'b10) |=> mem_we[h] && !rsp_sc_ok[h]);
        p_read_no_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[h] && !req_op[h*2+1]) |=> !mem_we[h] && !rsp_sc_ok[h]);
        // R1, R2: a store-conditional writes exactly when it succeeds
        p_sc_write_iff_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[h] && req_op[h*2 +: 2] == 2'b11) |=> mem_we[h] == rsp_sc_ok[h]);
        // R11: same-cycle context switch voids the store-conditional
        p_ctx_voids_sc_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[h] && req_op[h*2 +: 2] == 2'b11 && ctx_switch[h]) |=> !rsp_sc_ok[h]);
        // R11: same-cycle outside write or eviction to the line voids it
        p_ext_voids_sc_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[h] && req_op[h*2 +: 2] == 2'b11 &&
             ((ext_wr_valid && ext_wr_addr[AW-1:OFF] == req_addr[h*AW+OFF +: AW-OFF]) ||
              (evict_valid && evict_addr[AW-1:OFF] == req_addr[h*AW+OFF +: AW-OFF])))
            |=> !rsp_sc_ok[h]);
        // R3: back-to-back store-conditionals to one line, the second fails
        p_repeat_sc_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[h] && req_op[h*2 +: 2] == 2'b11 &&
             $past(req_valid[h] && req_op[h*2 +: 2] == 2'b11) &&
             $past(req_addr[h*AW+OFF +: AW-OFF]) == req_addr[h*AW+OFF +: AW-OFF])
            |=> !rsp_sc_ok[h]);
        for (genvar j = h + 1; j < HARTS; j++) begin : g_j
            // R10: never two successful store-conditionals to one line in a cycle
            p_single_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (rsp_sc_ok[h] && rsp_sc_ok[j]) |->
                mem_addr[h*AW+OFF +: AW-OFF] != mem_addr[j*AW+OFF +: AW-OFF]);
        end
    end
endmodule

bind llsc_monitor llsc_monitor_chk #(
    .HARTS(HARTS), .AW(AW), .LINE_BYTES(LINE_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .ext_wr_valid(ext_wr_valid), .ext_wr_addr(ext_wr_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .ctx_switch(ctx_switch),
    .rsp_valid(rsp_valid), .rsp_sc_ok(rsp_sc_ok), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
    localparam int H  = 3;
    localparam int S  = 2;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int LB = 4;
    localparam logic [1:0] LD = 2'b00, LL = 2'b01, ST = 2'b10, SC = 2'b11;
    localparam logic [7:0] LA = 8'h10, LBN = 8'h20, LC = 8'h30;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [H-1:0]    req_valid, rsp_valid, rsp_sc_ok, mem_we, ctx_switch;
    logic [H*2-1:0]  req_op;
    logic [H*AW-1:0] req_addr, mem_addr;
    logic [H*DW-1:0] req_wdata, mem_wdata;
    logic            ext_wr_valid, evict_valid;
    logic [AW-1:0]   ext_wr_addr, evict_addr;

    logic            b_v [H];
    logic [1:0]      b_op [H];
    logic [7:0]      b_ad [H];
    logic [7:0]      b_wd [H];
    logic            r_ok [H];
    logic            r_we [H];
    logic            r_rv [H];
    logic [7:0]      r_ad [H];
    logic [7:0]      r_wd [H];
    int checks = 0, errors = 0;
    bit done = 0;

    always_comb
        for (int h = 0; h < H; h++) begin
            req_valid[h]          = b_v[h];
            req_op[h*2 +: 2]      = b_op[h];
            req_addr[h*AW +: AW]  = b_ad[h];
            req_wdata[h*DW +: DW] = b_wd[h];
        end

    llsc_monitor #(.HARTS(H), .SLOTS(S), .AW(AW), .DW(DW), .LINE_BYTES(LB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ext_wr_valid(ext_wr_valid), .ext_wr_addr(ext_wr_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .ctx_switch(ctx_switch),
        .rsp_valid(rsp_valid), .rsp_sc_ok(rsp_sc_ok), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic idle();
        for (int h = 0; h < H; h++) begin
            b_v[h] = 0; b_op[h] = LD; b_ad[h] = '0; b_wd[h] = '0;
        end
        ext_wr_valid = 0; ext_wr_addr = '0;
        evict_valid = 0; evict_addr = '0; ctx_switch = '0;
    endtask

    task automatic put(int h, logic [1:0] op, logic [7:0] ad, logic [7:0] wd);
        b_v[h] = 1; b_op[h] = op; b_ad[h] = ad; b_wd[h] = wd;
    endtask

    // Clock one cycle; capture the registered outputs after the edge
    task automatic cyc();
        @(posedge clk); #1;
        for (int h = 0; h < H; h++) begin
            r_ok[h] = rsp_sc_ok[h]; r_we[h] = mem_we[h]; r_rv[h] = rsp_valid[h];
            r_ad[h] = mem_addr[h*AW +: AW]; r_wd[h] = mem_wdata[h*DW +: DW];
        end
        @(negedge clk);
        idle();
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        ctx_switch = '1; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // Reset state
        for (int h = 0; h < H; h++) begin
            chk("reset rsp_valid", int'(rsp_valid[h]), 0);
            chk("reset mem_we", int'(mem_we[h]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 basic pair with write data, R13 response valid
        for (int h = 0; h < H; h++) begin
            put(h, LL, LA, 0); cyc();
            chk("R13 ll rsp_valid", int'(r_rv[h]), 1);
            chk("R13 ll no write", int'(r_we[h]), 0);
            put(h, SC, LA + 8'd3, 8'hA0 + 8'(h)); cyc();
            chk("R1 sc ok", int'(r_ok[h]), 1);
            chk("R1 sc write", int'(r_we[h]), 1);
            chk("R1 sc addr", int'(r_ad[h]), int'(LA) + 3);
            chk("R1 sc data", int'(r_wd[h]), 'hA0 + h);
            // R2 no reservation now
            put(h, SC, LA, 8'h11); cyc();
            chk("R2 sc without link", int'(r_ok[h]), 0);
            chk("R2 sc without link write", int'(r_we[h]), 0);
        end

        // Sweep: intervening op by any hart (R3 R4 R8 R13)
        for (int a = 0; a < H; a++)
            for (int b = 0; b < H; b++)
                for (int kind = 0; kind < 5; kind++)
                    for (int same = 0; same < 2; same++) begin
                        logic [7:0] bad;
                        bit exp_ok, exp_bok, exp_bwe;
                        clear_all();
                        bad = same ? LA + 8'd2 : LBN;
                        put(a, LL, LA, 0); cyc();
                        if (kind == 1) put(b, LD, bad, 0);
                        if (kind == 2) put(b, LL, bad, 0);
                        if (kind == 3) put(b, ST, bad, 8'h33);
                        if (kind == 4) put(b, SC, bad, 8'h44);
                        if (kind != 0) begin
                            cyc();
                            exp_bok = (kind == 4) && (b == a) && same;
                            exp_bwe = (kind == 3) || exp_bok;
                            chk("R13 mid rsp_valid", int'(r_rv[b]), 1);
                            chk("R2 mid sc result", int'(r_ok[b]), int'(exp_bok));
                            chk("R13 mid write", int'(r_we[b]), int'(exp_bwe));
                        end
                        exp_ok = 1;
                        if (same && kind == 3) exp_ok = 0;          // R4 / R8
                        if (same && kind == 4 && b == a) exp_ok = 0; // R3
                        put(a, SC, LA + 8'd1, 8'h5A); cyc();
                        chk("R4 sweep sc result", int'(r_ok[a]), int'(exp_ok));
                        chk("R4 sweep sc write", int'(r_we[a]), int'(exp_ok));
                    end

        // Sweep: outside write, eviction, context switch at three timings (R5 R6 R7 R11 R12)
        for (int h = 0; h < H; h++)
            for (int ev = 0; ev < 4; ev++)
                for (int same = 0; same < 2; same++)
                    for (int tm = 0; tm < 3; tm++) begin
                        logic [7:0] ead;
                        bit exp_ok;
                        ead = same ? LA + 8'd3 : LC;
                        clear_all();
                        if (tm == 2) begin
                            if (ev == 0) begin ext_wr_valid = 1; ext_wr_addr = ead; end
                            if (ev == 1) begin evict_valid = 1; evict_addr = ead; end
                            if (ev == 2) ctx_switch[h] = 1'b1;
                            if (ev == 3) ctx_switch[(h+1)%H] = 1'b1;
                        end
                        put(h, LL, LA, 0); cyc();
                        if (tm == 0) begin
                            if (ev == 0) begin ext_wr_valid = 1; ext_wr_addr = ead; end
                            if (ev == 1) begin evict_valid = 1; evict_addr = ead; end
                            if (ev == 2) ctx_switch[h] = 1'b1;
                            if (ev == 3) ctx_switch[(h+1)%H] = 1'b1;
                            cyc();
                        end
                        if (tm == 1) begin
                            if (ev == 0) begin ext_wr_valid = 1; ext_wr_addr = ead; end
                            if (ev == 1) begin evict_valid = 1; evict_addr = ead; end
                            if (ev == 2) ctx_switch[h] = 1'b1;
                            if (ev == 3) ctx_switch[(h+1)%H] = 1'b1;
                        end
                        put(h, SC, LA, 8'h77); cyc();
                        exp_ok = (ev == 2) ? 0 : (ev == 3) ? 1 : !same;
                        if (ev == 0) chk("R5 R11 R12 outside write", int'(r_ok[h]), int'(exp_ok));
                        if (ev == 1) chk("R6 R11 R12 eviction", int'(r_ok[h]), int'(exp_ok));
                        if (ev >= 2) chk("R7 R11 R12 context switch", int'(r_ok[h]), int'(exp_ok));
                        chk("R2 event sweep write", int'(r_we[h]), int'(exp_ok));
                    end

        // Same-cycle contest between two harts (R10)
        for (int i = 0; i < H; i++)
            for (int j = i + 1; j < H; j++)
                for (int same = 0; same < 2; same++) begin
                    logic [7:0] jad;
                    jad = same ? LA + 8'd1 : LBN;
                    clear_all();
                    put(i, LL, LA, 0); put(j, LL, jad, 0); cyc();
                    put(i, SC, LA, 8'h01); put(j, SC, jad, 8'h02); cyc();
                    chk("R10 lower hart wins", int'(r_ok[i]), 1);
                    chk("R10 higher hart result", int'(r_ok[j]), int'(!same));
                    chk("R10 loser no write", int'(r_we[j]), int'(!same));
                    put(j, SC, jad, 8'h03); cyc();
                    chk("R3 R10 link gone after sc", int'(r_ok[j]), 0);
                end
        // Three-way contest
        clear_all();
        for (int h = 0; h < H; h++) put(h, LL, LA, 0);
        cyc();
        for (int h = 0; h < H; h++) put(h, SC, LA + 8'(h), 8'(h));
        cyc();
        for (int h = 0; h < H; h++)
            chk("R10 three-way", int'(r_ok[h]), int'(h == 0));

        // Multiple slots and rotating replacement (R9)
        for (int h = 0; h < H; h++) begin
            int vict;
            vict = 0;
            clear_all();
            put(h, LL, LA, 0); cyc();
            put(h, LL, LBN, 0); cyc();
            put(h, LL, LA + 8'd2, 0); cyc();   // same line refreshes, no replacement
            put(h, SC, LBN, 8'h21); cyc();
            chk("R9 two lines held B", int'(r_ok[h]), 1);
            put(h, SC, LA, 8'h22); cyc();
            chk("R9 two lines held A", int'(r_ok[h]), 1);
            for (int rnd = 0; rnd < 3; rnd++) begin
                clear_all();
                put(h, LL, LA, 0); cyc();
                put(h, LL, LBN, 0); cyc();
                put(h, LL, LC, 0); cyc();
                put(h, SC, LA, 8'h31); cyc();
                chk("R9 replacement A", int'(r_ok[h]), int'(vict != 0));
                put(h, SC, LBN, 8'h32); cyc();
                chk("R9 replacement B", int'(r_ok[h]), int'(vict == 0));
                put(h, SC, LC, 8'h33); cyc();
                chk("R9 replacement C", int'(r_ok[h]), 1);
                vict = (vict + 1) % S;
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule